// File: doc/BRIEF.md
# Adaptive Threshold Detector with Conversion-Count Timeouts

This block watches a stream of 12-bit conversion results and raises a detection flag when a result lies beyond a threshold. The threshold is either a programmable constant or a band around a slowly moving average of past results. A strobe marks each new result. The block samples that result, compares it, updates the average and registers the flag. Both outputs change only in the clock cycle after a strobe.

In adaptive mode the average follows the data through a shift-based first-order filter. The first result after reset seeds the average. A run of results outside the band on one side arms a timeout counter. Results on the side that moves toward the active threshold count against an approaching limit. Results on the other side count against a receding limit. When the count reaches its power-of-two limit, the average is overwritten with the current result. The band then follows the data at once and all filter history is lost.

Top module: `adaptive_thresh_det`

## Requirements
- R1: After reset, detect is 0 and average is 0. The first strobed result after reset is loaded directly into average. Its comparison uses the result itself as the reference, so in adaptive mode it never detects.
- R2: detect and average change only on the clock edge where resultValid is 1. They become visible in the cycle after that edge and hold while resultValid is 0.
- R3: With modeAdaptive=0, the reference is fixedThreshold. Polarity 2'b00 detects data > fixedThreshold. Polarity 2'b01 detects data < fixedThreshold. Polarity 2'b10 or 2'b11 (window) detects data != fixedThreshold.
- R4: With modeAdaptive=1, the upper threshold is average+sensitivity and the lower threshold is average−sensitivity. Both are computed without wrap, and sensitivity is aligned to result bit 0. Positive polarity detects data above the upper threshold, negative polarity detects data below the lower one, and window polarity detects either. All comparisons are strict.
- R5: On a strobe that does not trigger a timeout, average becomes average + ((data − average) >>> settleShift), using an arithmetic shift. With settleShift=0 the average equals the data.
- R6: The approaching side is "above" for positive polarity, "below" for negative polarity, and both sides for window polarity. In adaptive mode, when 2^timeoutCfg[7:4] consecutive results lie outside the band on the approaching side, the last of them overwrites average.
- R7: The receding side is the opposite side, used for positive and negative polarity only. Its limit is 2^timeoutCfg[3:0] consecutive results, and the last of them overwrites average.
- R8: The consecutive count restarts when a result falls inside the band, including the band edges. It also restarts at 1 when a result lands on the other side from the previous one. After a timeout the count starts again from zero.
- R9: timeoutCfg = 0 disables both timeouts. Fixed mode never triggers a timeout.
- R10: The detection decision in the cycle of a timeout uses the average as it was before that result overwrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| resultValid | input | 1 | One-cycle strobe marking a new result |
| resultData | input | 12 | Conversion result |
| modeAdaptive | input | 1 | 1 = adaptive band, 0 = fixed threshold |
| polarity | input | 2 | 00 positive, 01 negative, 1x window |
| sensitivity | input | 8 | Band half-width in result LSBs |
| timeoutCfg | input | 8 | [7:4] approaching exponent, [3:0] receding exponent, 0 disables |
| settleShift | input | 3 | Filter shift K |
| fixedThreshold | input | 12 | Constant threshold for fixed mode |
| detect | output | 1 | Registered detection flag |
| average | output | 12 | Current running average |

## Verification
The hardest case to reach is a timeout. It needs an unbroken run of out-of-band results on one side. A slow filter must keep the average from drifting toward the data first, and a side switch or an in-band result restarts the run. The sweep uses small exponents (limits of 1, 2 and 4), a sensitivity of 64 and phased data blocks of six results far above, far below and inside the band, so runs both complete and get interrupted. Directed sequences then pin down the exact result on which the overwrite lands, with the filter set to its slowest shift.

// File: rtl/atd_pkg.sv
package atd_pkg;
  typedef enum logic [1:0] {
    SIDE_IN    = 2'd0,
    SIDE_ABOVE = 2'd1,
    SIDE_BELOW = 2'd2
  } side_e;

  // strobes from control to datapath, at most one set per cycle
  typedef struct packed {
    logic init;  // seed average with data
    logic snap;  // timeout: overwrite average with data
    logic filt;  // normal filtered update
  } ctl_s;

  localparam logic [1:0] POL_POS = 2'b00;
  localparam logic [1:0] POL_NEG = 2'b01;
endpackage

// File: rtl/atd_datapath.sv
module atd_datapath
  import atd_pkg::*;
#(
  parameter int DW = 12,
  parameter int SW = 8,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          resultValid,
  input  logic [DW-1:0] resultData,
  input  logic          modeAdaptive,
  input  logic [1:0]    polarity,
  input  logic [SW-1:0] sensitivity,
  input  logic [KW-1:0] settleShift,
  input  logic [DW-1:0] fixedThreshold,
  input  logic          seeded,
  input  ctl_s          ctl,
  output side_e         side,
  output logic          detect,
  output logic [DW-1:0] average
);
  localparam int XW = DW + 2;

  logic signed [XW-1:0] dataX, refX, sensX, hiX, loX, diffX, stepX, nextAvgX;
  logic                 detNext;

  always_comb begin
    dataX = $signed({2'b00, resultData});
    refX  = seeded ? $signed({2'b00, average}) : dataX;
    sensX = $signed({{(XW-SW){1'b0}}, sensitivity});
    if (modeAdaptive) begin
      hiX = refX + sensX;
      loX = refX - sensX;
    end else begin
      hiX = $signed({2'b00, fixedThreshold});
      loX = hiX;
    end
    unique case (polarity)
      POL_POS: detNext = dataX > hiX;
      POL_NEG: detNext = dataX < loX;
      default: detNext = (dataX > hiX) || (dataX < loX);
    endcase
    if (dataX > refX + sensX)      side = SIDE_ABOVE;
    else if (dataX < refX - sensX) side = SIDE_BELOW;
    else                           side = SIDE_IN;
    diffX    = dataX - $signed({2'b00, average});
    stepX    = diffX >>> settleShift;
    nextAvgX = $signed({2'b00, average}) + stepX;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detect  <= 1'b0;
      average <= '0;
    end else if (resultValid) begin
      detect <= detNext;
      if (ctl.init || ctl.snap) average <= resultData;
      else if (ctl.filt)        average <= nextAvgX[DW-1:0];
    end
  end
endmodule

// File: rtl/atd_control.sv
module atd_control
  import atd_pkg::*;
#(
  parameter int EXPW = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            resultValid,
  input  logic            modeAdaptive,
  input  logic [1:0]      polarity,
  input  logic [2*EXPW-1:0] timeoutCfg,
  input  side_e           side,
  output logic            seeded,
  output ctl_s            ctl
);
  localparam int CNTW = (1 << EXPW) + 1;

  side_e           prevSide;
  logic [CNTW-1:0] cnt, nextCnt, limit;
  logic [EXPW-1:0] expSel;
  logic            approach, armed;

  always_comb begin
    approach = polarity[1]
            || (polarity == POL_POS && side == SIDE_ABOVE)
            || (polarity == POL_NEG && side == SIDE_BELOW);
    expSel   = approach ? timeoutCfg[2*EXPW-1:EXPW] : timeoutCfg[EXPW-1:0];
    limit    = CNTW'(1) << expSel;
    nextCnt  = (side == prevSide) ? cnt + CNTW'(1) : CNTW'(1);
    armed    = seeded && modeAdaptive && (timeoutCfg != '0) && (side != SIDE_IN);
    ctl.init = resultValid && !seeded;
    ctl.snap = resultValid && armed && (nextCnt >= limit);
    ctl.filt = resultValid && seeded && !ctl.snap;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seeded   <= 1'b0;
      cnt      <= '0;
      prevSide <= SIDE_IN;
    end else if (resultValid) begin
      seeded <= 1'b1;
      if (!armed || ctl.snap) begin
        cnt      <= '0;
        prevSide <= SIDE_IN;
      end else begin
        cnt      <= nextCnt;
        prevSide <= side;
      end
    end
  end
endmodule

// File: rtl/adaptive_thresh_det.sv
module adaptive_thresh_det
  import atd_pkg::*;
#(
  parameter int DW   = 12,
  parameter int SW   = 8,
  parameter int EXPW = 4,
  parameter int KW   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resultValid,
  input  logic [DW-1:0]     resultData,
  input  logic              modeAdaptive,
  input  logic [1:0]        polarity,
  input  logic [SW-1:0]     sensitivity,
  input  logic [2*EXPW-1:0] timeoutCfg,
  input  logic [KW-1:0]     settleShift,
  input  logic [DW-1:0]     fixedThreshold,
  output logic              detect,
  output logic [DW-1:0]     average
);
  ctl_s  ctlS;
  side_e sideS;
  logic  seededS;

  atd_control #(.EXPW(EXPW)) u_ctl (
    .clk(clk), .rstN(rstN), .resultValid(resultValid),
    .modeAdaptive(modeAdaptive), .polarity(polarity),
    .timeoutCfg(timeoutCfg), .side(sideS),
    .seeded(seededS), .ctl(ctlS)
  );

  atd_datapath #(.DW(DW), .SW(SW), .KW(KW)) u_dp (
    .clk(clk), .rstN(rstN), .resultValid(resultValid),
    .resultData(resultData), .modeAdaptive(modeAdaptive),
    .polarity(polarity), .sensitivity(sensitivity),
    .settleShift(settleShift), .fixedThreshold(fixedThreshold),
    .seeded(seededS), .ctl(ctlS), .side(sideS),
    .detect(detect), .average(average)
  );
endmodule

// File: rtl/atd_checker.sv
module atd_checker
  import atd_pkg::*;
#(
  parameter int DW   = 12,
  parameter int EXPW = 4,
  parameter int KW   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              resultValid,
  input logic [DW-1:0]     resultData,
  input logic              modeAdaptive,
  input logic [1:0]        polarity,
  input logic [DW-1:0]     fixedThreshold,
  input logic [2*EXPW-1:0] timeoutCfg,
  input logic [KW-1:0]     settleShift,
  input ctl_s              ctlS,
  input logic              detect,
  input logic [DW-1:0]     average
);
  // R2
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |=> $stable(average) && $stable(detect));

  // R1
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlS.init |=> average == $past(resultData));

  // R6
  snap_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlS.snap |=> average == $past(resultData));

  // R5
  track_k0_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctlS.filt && settleShift == '0) |=> average == $past(resultData));

  // R9
  timeout_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutCfg == '0 || !modeAdaptive) |-> !ctlS.snap);

  // R3
  fixed_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !modeAdaptive && polarity == POL_POS)
      |=> detect == ($past(resultData) > $past(fixedThreshold)));

  // R2
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctlS.init, ctlS.snap, ctlS.filt}));
endmodule

bind adaptive_thresh_det atd_checker #(.DW(DW), .EXPW(EXPW), .KW(KW)) u_chk (
  .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultData(resultData),
  .modeAdaptive(modeAdaptive), .polarity(polarity),
  .fixedThreshold(fixedThreshold), .timeoutCfg(timeoutCfg),
  .settleShift(settleShift), .ctlS(ctlS), .detect(detect), .average(average)
);

// File: tb/sim_adaptive_thresh_det.sv
module sim_adaptive_thresh_det;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resultValid = 1'b0;
  logic [11:0] resultData = '0;
  logic        modeAdaptive = 1'b0;
  logic [1:0]  polarity = '0;
  logic [7:0]  sensitivity = 8'd64;
  logic [7:0]  timeoutCfg = '0;
  logic [2:0]  settleShift = '0;
  logic [11:0] fixedThreshold = 12'd2048;
  logic        detect;
  logic [11:0] average;

  int nChecks = 0, nFails = 0;
  bit done = 0;

  // bench model state
  int  mAvg, mCnt, mSide;
  bit  mSeeded, mDet;
  int  lcg = 12345;

  adaptive_thresh_det u0 (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultData(resultData),
    .modeAdaptive(modeAdaptive), .polarity(polarity), .sensitivity(sensitivity),
    .timeoutCfg(timeoutCfg), .settleShift(settleShift),
    .fixedThreshold(fixedThreshold), .detect(detect), .average(average)
  );

  always #10 clk = ~clk;  // 50 MHz

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    resultValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    mAvg = 0; mCnt = 0; mSide = 0; mSeeded = 0; mDet = 0;
  endtask

  // expected behaviour from the requirements; side 0 in, 1 above, 2 below
  task automatic model(input int d);
    int r, hi, lo, s, n, e, lim;
    bit appr;
    r  = mSeeded ? mAvg : d;                       // R1
    hi = modeAdaptive ? r + sensitivity : fixedThreshold;   // R3 R4
    lo = modeAdaptive ? r - sensitivity : fixedThreshold;
    case (polarity)
      2'b00: mDet = d > hi;
      2'b01: mDet = d < lo;
      default: mDet = (d > hi) || (d < lo);
    endcase
    s = (d > r + sensitivity) ? 1 : (d < r - sensitivity) ? 2 : 0;
    if (!mSeeded) begin
      mAvg = d; mSeeded = 1; mCnt = 0; mSide = 0;
    end else if (modeAdaptive && timeoutCfg != 0 && s != 0) begin
      n    = (s == mSide) ? mCnt + 1 : 1;         // R8
      appr = polarity[1] || (polarity == 2'b00 && s == 1) || (polarity == 2'b01 && s == 2);
      e    = appr ? timeoutCfg[7:4] : timeoutCfg[3:0];  // R6 R7
      lim  = 1 << e;
      if (n >= lim) begin
        mAvg = d; mCnt = 0; mSide = 0;
      end else begin
        mCnt = n; mSide = s;
        mAvg = mAvg + ((d - mAvg) >>> settleShift);  // R5
      end
    end else begin
      mCnt = 0; mSide = 0;                          // R9
      mAvg = mAvg + ((d - mAvg) >>> settleShift);
    end
  endtask

  task automatic sample(input int d, input string req);
    resultData  = 12'(d);
    resultValid = 1'b1;
    model(d);
    @(negedge clk);
    resultValid = 1'b0;
    check({req, " detect"}, int'(detect), int'(mDet));
    check({req, " average"}, int'(average), mAvg);
  endtask

  function automatic int nextData(input int i);
    int ph;
    ph  = (i / 6) % 4;
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    case (ph)
      0: return 2048 + (lcg % 129) - 64;
      1: return 2500 + (lcg % 50);
      2: return 1500 - (lcg % 50);
      default: return 1000 + (lcg % 2000);
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] tcfgs [4] = '{8'h00, 8'h21, 8'h12, 8'h10};
    doReset();
    // R1 reset state
    check("R1 reset detect", int'(detect), 0);
    check("R1 reset average", int'(average), 0);
    // R2 idle cycles hold state
    repeat (3) @(negedge clk);
    check("R2 idle average", int'(average), 0);

    // sweep: polarity x mode x shift x timeout config
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 2; m++)
        for (int k = 0; k < 2; k++)
          for (int t = 0; t < 4; t++) begin
            polarity = 2'(p); modeAdaptive = m[0];
            settleShift = k ? 3'd2 : 3'd0; timeoutCfg = tcfgs[t];
            doReset();
            for (int i = 0; i < 40; i++) begin
              sample(nextData(i), m ? "R4 R6 R7 R8 R9 R10" : "R3 R9");
              if (i % 7 == 3) begin
                @(negedge clk);
                check("R2 hold average", int'(average), mAvg);
                check("R2 hold detect", int'(detect), int'(mDet));
              end
            end
          end

    // R6 directed: positive, approaching limit 4, slowest filter
    polarity = 2'b00; modeAdaptive = 1; settleShift = 3'd7; timeoutCfg = 8'h20;
    doReset();
    sample(2000, "R1 seed");
    check("R1 seed value", int'(average), 2000);
    sample(2500, "R6 a1"); sample(2500, "R6 a2"); sample(2500, "R6 a3");
    check("R6 before limit", int'(average), 2009);
    sample(2500, "R6 a4");
    check("R6 overwrite on 4th", int'(average), 2500);
    check("R10 detect uses old average", int'(detect), 1);

    // R8 directed: in-band result restarts the run
    doReset();
    sample(2000, "R8"); sample(2500, "R8"); sample(2500, "R8"); sample(2500, "R8");
    sample(2010, "R8 in band");
    sample(2500, "R8"); sample(2500, "R8"); sample(2500, "R8");
    check("R8 no overwrite after restart", int'(average != 2500), 1);
    sample(2500, "R8");
    check("R8 overwrite after 4 fresh", int'(average), 2500);

    // R7 directed: positive polarity, receding limit 2 below band
    timeoutCfg = 8'hF1;
    doReset();
    sample(2000, "R7"); sample(1500, "R7");
    check("R7 not yet", int'(average != 1500), 1);
    sample(1500, "R7");
    check("R7 overwrite on 2nd", int'(average), 1500);

    // R9 directed: disabled timeouts never overwrite
    timeoutCfg = 8'h00;
    doReset();
    sample(2000, "R9");
    for (int i = 0; i < 6; i++) sample(2500, "R9");
    check("R9 no overwrite", int'(average != 2500), 1);

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule